// File: doc/BRIEF.md
# Multi-channel compare match timer

A timer block with several independent channels behind a small register bus. Each channel owns an up-counter that advances once per prescaled clock period, a compare register, and a control/status register. When a counting step finds the counter equal to the compare value, the counter returns to zero, keeps running and raises a sticky match flag. The interval between flags is therefore `(compare + 1) * DIV` input clocks. The flag, qualified by a per-channel interrupt enable, drives that channel's interrupt line.

One start register is shared by the whole group and holds a run bit for each channel. Software can rewrite the compare register while the channel runs. A compare value below the current count is only reached after the counter wraps through zero. A parameter selects the wide build (32-bit counters, divide by 8) or the narrow build (16-bit counters, divide by 512). A counter write restarts the prescaler phase, so the first step after the write comes one full period later.

Top module: `cmt_timer`

## Requirements
- R1: After reset every run bit is 0, every counter reads 0, every compare register reads all-ones, every control/status register reads 0 and every `irq` bit is 0.
- R2: The start register is at byte address 0, and bit c is the run bit of channel c. Channel c occupies a window at byte `(c+1)*16` in the wide build (`(c+1)*8` in the narrow build). Inside the window, control/status is at offset 0, the counter at 4 and the compare at 8 (0, 2 and 4 in the narrow build). Reads of unmapped or misaligned addresses return 0, and writes to them change nothing.
- R3: A channel's counter advances by exactly one every DIV input clocks, and only while its run bit is 1. With the run bit at 0 the counter holds its value. The first step comes DIV clocks after the run bit is written.
- R4: On a step where the counter equals the compare value, the counter becomes 0 and the match flag sets. The flag is bit 15 of control/status in the wide build and bit 7 in the narrow build.
- R5: Writing 0 to a status bit clears it. Writing 1 to a status bit leaves it unchanged. All other control/status bits take the written value. A match in the same cycle as a clearing write leaves the flag set.
- R6: `irq[c]` is 1 exactly when channel c's match flag and its interrupt-enable bit are both 1. The enable is bit 5 in the wide build and bit 6 in the narrow build. Writing 0 to control/status therefore removes the interrupt.
- R7: Wide build only: a match while the match flag is still set also sets the overrun bit, bit 14 of control/status. It is cleared like the match flag.
- R8: The compare register may be rewritten while the channel runs. A new value below the current count produces no match until the counter has wrapped through zero and counted up to it.
- R9: A counter write loads the value on the next clock edge and restarts the prescaler phase, so the next step comes DIV clocks after the write.
- R10: Channels are independent. Running, matching or writing one channel does not change another channel's counter or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address while `bus_sel` is 1 |
| irq | output | NUM_CH | Per-channel interrupt, flag AND enable |

## Verification
Register writes take effect at the clock edge that samples them, and reads show the new state in the same cycle after that edge. A run-bit or counter write at edge W places the first counter step at edge W+8 in the wide build. The flag and the interrupt follow the compare match at the same edge as the counter clear. The bench schedules each read at an exact cycle offset from the write that started the sequence. It samples mid-cycle, one cycle before and at the edge where a value is due, so an off-by-one in the prescaler or the match logic shows up as a mismatch.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  // Counter value after one counting step: clear on compare, else increment.
  function automatic logic [31:0] cmt_next_count(input logic [31:0] cnt,
                                                 input logic [31:0] cmp);
    return (cnt == cmp) ? 32'd0 : cnt + 32'd1;
  endfunction

  // Control/status write: status bits can only be cleared, others are loaded.
  function automatic logic [15:0] cmt_csr_merge(input logic [15:0] old_v,
                                                input logic [15:0] wr_v,
                                                input logic [15:0] stat_mask);
    return (old_v & wr_v & stat_mask) | (wr_v & ~stat_mask);
  endfunction

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int DIV_LOG2 = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  logic [DIV_LOG2-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                phase_q <= '0;
    else if (restart || !run)  phase_q <= '0;
    else                       phase_q <= phase_q + 1'b1;
  end

  assign tick = run && (phase_q == '1);
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int DIV_LOG2 = 3,
  parameter bit WIDE     = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             csr_we,
  input  logic             cnt_we,
  input  logic             cmp_we,
  input  logic [31:0]      wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cmp_q,
  output logic [15:0]      csr_q,
  output logic             tick_o,
  output logic             match_o,
  output logic             irq_o
);
  localparam int          FLAG_BIT  = WIDE ? 15 : 7;
  localparam int          OVR_BIT   = 14;
  localparam int          IE_BIT    = WIDE ? 5 : 6;
  localparam logic [15:0] STAT_MASK = WIDE ? 16'hC000 : 16'h0080;

  logic        tick;
  logic        match;
  logic [15:0] csr_nxt;

  cmt_prescaler #(.DIV_LOG2(DIV_LOG2)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .restart(cnt_we),
    .tick   (tick)
  );

  assign match = tick && !cnt_we && (cnt_q == cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cnt_we)  cnt_q <= wdata[CNT_W-1:0];
    else if (tick)    cnt_q <= CNT_W'(cmt_next_count(32'(cnt_q), 32'(cmp_q)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cmp_q <= '1;
    else if (cmp_we)  cmp_q <= wdata[CNT_W-1:0];
  end

  always_comb begin
    csr_nxt = csr_we ? cmt_csr_merge(csr_q, wdata[15:0], STAT_MASK) : csr_q;
    if (match) begin
      if (WIDE && csr_nxt[FLAG_BIT]) csr_nxt[OVR_BIT] = 1'b1;
      csr_nxt[FLAG_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) csr_q <= '0;
    else        csr_q <= csr_nxt;
  end

  assign tick_o  = tick;
  assign match_o = match;
  assign irq_o   = csr_q[FLAG_BIT] & csr_q[IE_BIT];
endmodule

// File: rtl/cmt_timer.sv
module cmt_timer #(
  parameter int NUM_CH   = 2,
  parameter bit WIDE     = 1'b1,
  parameter int ADDR_W   = 8,
  parameter int DIV_LOG2 = WIDE ? 3 : 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int CNT_W     = WIDE ? 32 : 16;
  localparam int SLOT_LOG2 = WIDE ? 4 : 3;
  localparam int REG_LOG2  = WIDE ? 2 : 1;
  localparam int IDX_W     = SLOT_LOG2 - REG_LOG2;

  logic                         wr_stb;
  logic [ADDR_W-1:0]            slot;
  logic [IDX_W-1:0]             ridx;
  logic                         aligned;
  logic [NUM_CH-1:0]            run_q;
  logic [NUM_CH-1:0]            csr_we_w, cnt_we_w, cmp_we_w;
  logic [NUM_CH-1:0]            tick_w, match_w;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_w, cmp_w;
  logic [NUM_CH-1:0][15:0]      csr_w;

  assign wr_stb  = bus_sel && bus_wr;
  assign slot    = ADDR_W'(bus_addr >> SLOT_LOG2);
  assign ridx    = bus_addr[SLOT_LOG2-1:REG_LOG2];
  assign aligned = (bus_addr[REG_LOG2-1:0] == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                          run_q <= '0;
    else if (wr_stb && bus_addr == '0)   run_q <= bus_wdata[NUM_CH-1:0];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit         = wr_stb && aligned && (slot == ADDR_W'(c + 1));
    assign csr_we_w[c] = hit && (ridx == IDX_W'(0));
    assign cnt_we_w[c] = hit && (ridx == IDX_W'(1));
    assign cmp_we_w[c] = hit && (ridx == IDX_W'(2));

    cmt_channel #(.CNT_W(CNT_W), .DIV_LOG2(DIV_LOG2), .WIDE(WIDE)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run_q[c]),
      .csr_we (csr_we_w[c]),
      .cnt_we (cnt_we_w[c]),
      .cmp_we (cmp_we_w[c]),
      .wdata  (bus_wdata),
      .cnt_q  (cnt_w[c]),
      .cmp_q  (cmp_w[c]),
      .csr_q  (csr_w[c]),
      .tick_o (tick_w[c]),
      .match_o(match_w[c]),
      .irq_o  (irq[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      if (bus_addr == '0) bus_rdata = 32'(run_q);
      for (int c = 0; c < NUM_CH; c++) begin
        if (aligned && slot == ADDR_W'(c + 1)) begin
          case (ridx)
            IDX_W'(0): bus_rdata = 32'(csr_w[c]);
            IDX_W'(1): bus_rdata = 32'(cnt_w[c]);
            IDX_W'(2): bus_rdata = 32'(cmp_w[c]);
            default:   bus_rdata = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/cmt_timer_chk.sv
module cmt_timer_chk #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32,
  parameter bit WIDE   = 1'b1
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_CH-1:0]            run,
  input logic [NUM_CH-1:0]            tick,
  input logic [NUM_CH-1:0]            match,
  input logic [NUM_CH-1:0]            cnt_we,
  input logic [NUM_CH-1:0]            csr_we,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt,
  input logic [NUM_CH-1:0][15:0]      csr,
  input logic [NUM_CH-1:0]            irq
);
  localparam int FLAG_BIT = WIDE ? 15 : 7;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_a
    a_r4_match_clears: assert property (@(posedge clk) disable iff (!rst_n)
      match[c] |=> (cnt[c] == '0) && csr[c][FLAG_BIT]);

    a_r3_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !run[c] && !cnt_we[c] |=> $stable(cnt[c]));

    a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      tick[c] && !match[c] && !cnt_we[c] |=> cnt[c] == CNT_W'($past(cnt[c]) + CNT_W'(1)));

    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      tick[c] |=> !tick[c]);

    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      csr[c][FLAG_BIT] && !csr_we[c] |=> csr[c][FLAG_BIT]);

    a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[c]) |-> $past(match[c] || csr_we[c]));

    if (WIDE) begin : g_ovr
      a_r7_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        match[c] && csr[c][FLAG_BIT] && !csr_we[c] |=> csr[c][14]);
    end
  end
endmodule

bind cmt_timer cmt_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .WIDE(WIDE)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .run   (run_q),
  .tick  (tick_w),
  .match (match_w),
  .cnt_we(cnt_we_w),
  .csr_we(csr_we_w),
  .cnt   (cnt_w),
  .csr   (csr_w),
  .irq   (irq)
);

// File: tb/test_cmt_timer.sv
`timescale 1ns/1ps
module test_cmt_timer;
  localparam int NUM_CH = 2;
  localparam logic [7:0] A_START = 8'h00;
  localparam logic [7:0] A_CSR0 = 8'h10, A_CNT0 = 8'h14, A_CMP0 = 8'h18;
  localparam logic [7:0] A_CSR1 = 8'h20, A_CNT1 = 8'h24, A_CMP1 = 8'h28;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]        bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [NUM_CH-1:0] irq;

  always #10 clk = ~clk;

  cmt_timer #(.NUM_CH(NUM_CH), .WIDE(1'b1), .ADDR_W(8)) i_cmt_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct { bit is_irq; logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  event  ev_chk;
  int    tests = 0, fails = 0;
  bit    done = 1'b0;

  // Scoreboard monitor: compares each queued expectation against the outputs.
  initial begin
    forever begin
      @(ev_chk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = q.pop_front();
        act = it.is_irq ? 32'(irq) : bus_rdata;
        tests++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    q.push_back('{1'b0, e, tag});
    -> ev_chk;
    #3;
  endtask

  task automatic irq_chk(input logic [NUM_CH-1:0] e, input string tag);
    q.push_back('{1'b1, 32'(e), tag});
    -> ev_chk;
    #3;
  endtask

  // Drives at once; the write lands at the next rising edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(A_START, 32'h0, "R1 start reg");
    rd(A_CNT0, 32'h0, "R1 counter");
    rd(A_CMP0, 32'hFFFF_FFFF, "R1 compare");
    rd(A_CSR0, 32'h0, "R1 csr");
    step(1);
    rd(A_CMP1, 32'hFFFF_FFFF, "R1 compare ch1");
    irq_chk(2'b00, "R1 irq");
    // R2 unmapped and misaligned addresses
    rd(8'h1C, 32'h0, "R2 unmapped");
    rd(8'h12, 32'h0, "R2 misaligned");

    // R3/R4/R6 periodic match, W = start write edge
    wr(A_CMP0, 32'd3);
    wr(A_CSR0, 32'h0020);
    wr(A_CMP1, 32'd1);
    wr(A_START, 32'h1);
    step(7);
    rd(A_CNT0, 32'd0, "R3 no step before DIV");
    step(1);
    rd(A_CNT0, 32'd1, "R3 first step");
    rd(A_CNT1, 32'd0, "R10 stopped ch1 still");
    step(23);
    rd(A_CNT0, 32'd3, "R4 at compare");
    rd(A_CSR0, 32'h0020, "R4 flag not yet");
    irq_chk(2'b00, "R6 no irq before match");
    step(1);
    rd(A_CNT0, 32'd0, "R4 cleared on match");
    rd(A_CSR0, 32'h8020, "R4 flag set");
    irq_chk(2'b01, "R6 irq with enable");
    wr(A_START, 32'h0);
    step(20);
    rd(A_CNT0, 32'd0, "R3 stopped holds");

    // R5 status write rules
    wr(A_CSR0, 32'h0000_C1A4);
    rd(A_CSR0, 32'h81A4, "R5 writing 1 keeps status");
    irq_chk(2'b01, "R6 irq still on");
    wr(A_CSR0, 32'h0000_0020);
    rd(A_CSR0, 32'h0020, "R5 writing 0 clears flag");
    irq_chk(2'b00, "R6 irq off after clear");

    // R7 overrun, interrupt disabled
    wr(A_CNT0, 32'd0);
    wr(A_CMP0, 32'd1);
    wr(A_CSR0, 32'h0);
    wr(A_START, 32'h1);
    step(15);
    rd(A_CSR0, 32'h0, "R7 before first match");
    step(1);
    rd(A_CSR0, 32'h8000, "R7 first match flag");
    irq_chk(2'b00, "R6 enable off no irq");
    step(16);
    rd(A_CSR0, 32'hC000, "R7 overrun set");
    rd(A_CNT0, 32'd0, "R4 second match clear");
    wr(A_CSR0, 32'h0);
    rd(A_CSR0, 32'h0, "R7 overrun cleared");
    wr(A_START, 32'h0);

    // R8/R9 compare rewrite below count, counter write restarts phase
    wr(A_CMP0, 32'hFFFF_FFF0);
    wr(A_START, 32'h1);
    step(2);
    wr(A_CNT0, 32'hFFFF_FFFE);
    wr(A_CMP0, 32'd5);
    step(6);
    rd(A_CNT0, 32'hFFFF_FFFE, "R9 phase restarted");
    step(1);
    rd(A_CNT0, 32'hFFFF_FFFF, "R9 step DIV after write");
    step(8);
    rd(A_CNT0, 32'd0, "R8 wrapped through zero");
    rd(A_CSR0, 32'h0, "R8 no match on wrap");
    step(40);
    rd(A_CNT0, 32'd5, "R8 reached new compare");
    rd(A_CSR0, 32'h0, "R8 flag not yet");
    step(8);
    rd(A_CNT0, 32'd0, "R8 match after wrap");
    rd(A_CSR0, 32'h8000, "R8 flag after wrap");
    wr(A_START, 32'h0);

    // R10 second channel alone
    wr(A_CSR1, 32'h0020);
    wr(A_START, 32'h2);
    step(16);
    rd(A_CSR1, 32'h8020, "R10 ch1 match");
    rd(A_CNT0, 32'd0, "R10 ch0 untouched");
    rd(A_CSR0, 32'h8000, "R10 ch0 flag kept");
    irq_chk(2'b10, "R10 irq ch1 only");
    step(1);
    rd(A_START, 32'h2, "R2 start reg readback");

    step(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule